// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst to a synchronous memory. On a load cycle it captures a full external address and records what kind of access is starting. The access is a read, a write, or a deselect when the chip-select result is inactive. On each following advance cycle it steps the two low address bits through the burst order. The upper bits keep the value taken at the load.

A strap input picks the order. In linear order the low bits count up from the start value and wrap modulo four. In interleaved order the low bits are the start value XORed with the beat number. Internally a two-bit beat counter is kept apart from the captured start value, and the presented address is derived from the two.

A clock-enable input stalls the block. While it is low, the counter and the recorded access type both hold. The memory array and the data path sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: On a cycle with `clk_en`=1 and `adv_ld`=0, the whole of `addr_in` is captured and appears on `cur_addr` from the next cycle. Beat 0 is the start address in both orders.
- R2: At a load, the access type is taken from `sel` and `wr_en` and shown on `op_type`: 2'b00 is deselect (`sel`=0), 2'b01 is read (`sel`=1, `wr_en`=0) and 2'b10 is write (`sel`=1, `wr_en`=1). `op_valid` is 1 exactly when `op_type` is read or write.
- R3: On a cycle with `clk_en`=1 and `adv_ld`=1, `sel` and `wr_en` have no effect, and `op_type` keeps the value recorded at the load.
- R4: With `seq_mode`=0 (linear), beat n has low bits (start + n) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `seq_mode`=1 (interleaved), beat n has low bits start XOR (n mod 4). For example, start 11 gives 11, 10, 01, 00.
- R6: Advancing past the fourth beat wraps, so beat 4 repeats the start address.
- R7: Advancing after a deselect load keeps `op_type` at deselect and `op_valid` at 0. Only a new load can begin an access.
- R8: A cycle with `clk_en`=0 leaves `cur_addr` (with `seq_mode` held) and `op_type` unchanged.
- R9: `cur_addr[ADDR_W-1:2]` stays equal to the loaded upper bits for every beat of the burst.
- R10: After reset, `cur_addr` is 0, `op_type` is deselect and `op_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address, captured on load |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new address |
| clk_en | input | 1 | 1 = act on this edge, 0 = stall |
| sel | input | 1 | Combined chip-select result, 1 = selected |
| wr_en | input | 1 | 1 = write, 0 = read; sampled on load only |
| seq_mode | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| cur_addr | output | ADDR_W | Address of the current beat |
| op_type | output | 2 | Recorded access: 00 deselect, 01 read, 10 write |
| op_valid | output | 1 | 1 while the recorded access is a read or write |

## Verification
The hardest state to reach from the ports is a stall in the middle of a burst, inside the wrap region past the fourth beat. It is harder still when `sel` and `wr_en` toggle during the stall and the following advances, because a fault there could change the recorded type or step the counter too early. The stimulus loads each start value in both orders, toggles `sel` and `wr_en` on every advance, and runs six advances so that the burst wraps. It also places `clk_en`-low cycles between advances. A behavioural model recomputes the expected address from the beat count with modulo and XOR arithmetic and compares it on every cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    BAG_DESEL = 2'b00,
    BAG_READ  = 2'b01,
    BAG_WRITE = 2'b10
  } bag_op_e;

  // linear order: start plus beat, wraps by width
  function automatic logic [BEAT_W-1:0] lin_pos(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] beat);
    return start + beat;
  endfunction

  // interleaved order: start XOR beat
  function automatic logic [BEAT_W-1:0] ilv_pos(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] beat);
    return start ^ beat;
  endfunction

  function automatic bag_op_e decode_op(input logic sel, input logic wr_en);
    if (!sel)  return BAG_DESEL;
    if (wr_en) return BAG_WRITE;
    return BAG_READ;
  endfunction
endpackage

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
  import burst_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              adv_evt,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat <= '0;
    else if (load_evt) beat <= '0;
    else if (adv_evt)  beat <= beat + 1'b1;
  end
endmodule

// File: rtl/bag_load_reg.sv
module bag_load_reg
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sel,
  input  logic              wr_en,
  output logic [ADDR_W-1:0] base_addr,
  output bag_op_e           op_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      op_q      <= BAG_DESEL;
    end else if (load_evt) begin
      base_addr <= addr_in;
      op_q      <= decode_op(sel, wr_en);
    end
  end
endmodule

// File: rtl/bag_low_mix.sv
module bag_low_mix
  import burst_addr_pkg::*;
(
  input  logic              seq_mode,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low_addr
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign lin_lo   = lin_pos(start_lo, beat);
  assign ilv_lo   = ilv_pos(start_lo, beat);
  assign low_addr = seq_mode ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv_ld,
  input  logic              clk_en,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              seq_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        op_type,
  output logic              op_valid
);
  logic              load_evt;
  logic              adv_evt;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] start_lo;
  logic [BEAT_W-1:0] low_addr;
  logic [ADDR_W-1:0] base_addr;
  bag_op_e           op_q;

  assign load_evt = clk_en & ~adv_ld;
  assign adv_evt  = clk_en &  adv_ld;

  bag_beat_ctr u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .beat     (beat)
  );

  bag_load_reg #(.ADDR_W(ADDR_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .addr_in   (addr_in),
    .sel       (sel),
    .wr_en     (wr_en),
    .base_addr (base_addr),
    .op_q      (op_q)
  );

  assign start_lo = base_addr[BEAT_W-1:0];

  bag_low_mix u_mix (
    .seq_mode (seq_mode),
    .start_lo (start_lo),
    .beat     (beat),
    .low_addr (low_addr)
  );

  assign cur_addr = {base_addr[ADDR_W-1:BEAT_W], low_addr};
  assign op_type  = op_q;
  assign op_valid = (op_q == BAG_READ) || (op_q == BAG_WRITE);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              adv_ld,
  input logic              clk_en,
  input logic              sel,
  input logic              wr_en,
  input logic              seq_mode,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        op_type,
  input logic              op_valid
);
  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_ld) |=> (cur_addr == $past(addr_in)));

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_ld && sel && wr_en) |=> (op_type == 2'b10 && op_valid));

  // R3
  adv_keeps_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_ld) |=> $stable(op_type));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_ld && !seq_mode) ##1 !seq_mode |->
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  // R7
  desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_ld && !sel) |=> !op_valid);

  // R8
  stall_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(op_type));

  // R8
  stall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en ##1 $stable(seq_mode) |-> $stable(cur_addr));

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_ld) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .adv_ld(adv_ld), .clk_en(clk_en),
  .sel(sel), .wr_en(wr_en), .seq_mode(seq_mode), .cur_addr(cur_addr),
  .op_type(op_type), .op_valid(op_valid)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              adv_ld = 1'b0;
  logic              clk_en = 1'b0;
  logic              sel = 1'b0;
  logic              wr_en = 1'b0;
  logic              seq_mode = 1'b0;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        op_type;
  logic              op_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_base = 0;
  int m_beats = 0;
  int m_op = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .adv_ld(adv_ld), .clk_en(clk_en),
    .sel(sel), .wr_en(wr_en), .seq_mode(seq_mode), .cur_addr(cur_addr),
    .op_type(op_type), .op_valid(op_valid)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_beats = 0; m_op = 0;
    end else if (clk_en) begin
      if (!adv_ld) begin
        m_base  = int'(addr_in);
        m_beats = 0;
        m_op    = !sel ? 0 : (wr_en ? 2 : 1);
      end else begin
        m_beats = m_beats + 1;
      end
    end
  end

  function automatic int exp_low();
    int s = m_base % 4;
    int n = m_beats % 4;
    if (seq_mode) return s ^ n;
    return (s + n) % 4;
  endfunction

  task automatic compare(input string tag);
    int want_lo = exp_low();
    int want_hi = m_base / 4;
    int got_hi  = int'(cur_addr) / 4;
    tests++;
    if (int'(cur_addr[1:0]) != want_lo) begin
      fails++;
      $display("FAIL %s low bits actual %0d expected %0d", tag, cur_addr[1:0], want_lo);
    end
    tests++;
    if (got_hi != want_hi) begin
      fails++;
      $display("FAIL R9 upper bits actual %0h expected %0h", got_hi, want_hi);
    end
    tests++;
    if (int'(op_type) != m_op || op_valid != (m_op != 0)) begin
      fails++;
      $display("FAIL R2/R3 op actual %0d/%0b expected %0d/%0b", op_type, op_valid, m_op, m_op != 0);
    end
  endtask

  // drive one cycle, then check after the edge
  task automatic cyc(input bit en, input bit adv, input bit s, input bit w,
                     input int a, input string tag);
    clk_en = en; adv_ld = adv; sel = s; wr_en = w; addr_in = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    tests++;
    if (cur_addr != '0 || op_type != 2'b00 || op_valid) begin
      fails++;
      $display("FAIL R10 reset actual %0h/%0d/%0b expected 0/0/0", cur_addr, op_type, op_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int md = 0; md < 2; md++) begin
      seq_mode = md[0];
      for (int st = 0; st < 4; st++) begin
        int a = (16'h5a3 + st * 37) * 4 + st;
        cyc(1, 0, 1, st[0], a, "R1");
        for (int k = 1; k <= 6; k++)
          cyc(1, 1, k[0], ~k[0], 0, k >= 4 ? "R6" : (md == 1 ? "R5" : "R4"));
      end
    end

    // R7 deselect then advance
    seq_mode = 1'b0;
    cyc(1, 0, 0, 1, 17'h1abc1, "R7");
    for (int k = 0; k < 3; k++) cyc(1, 1, 1, k[0], 0, "R7");

    // R8 stalls mid burst with toggling controls
    for (int md = 0; md < 2; md++) begin
      seq_mode = md[0];
      cyc(1, 0, 1, 1, 17'h0f0f2, "R1");
      for (int k = 0; k < 6; k++) begin
        cyc(0, k[0], ~k[0], k[1], 17'h1ffff, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        cyc(1, 1, k[1], k[0], 0, "R6");
      end
    end

    // R1 reload in the middle of a burst
    cyc(1, 0, 1, 0, 17'h00007, "R1");
    cyc(1, 1, 0, 1, 0, "R3");
    cyc(1, 0, 1, 1, 17'h12344, "R1");
    cyc(1, 1, 1, 0, 0, "R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule